// File: doc/BRIEF.md
# Interrupt Mapping and Gating Controller

This block gathers the level-sensitive interrupt requests of a host bridge and passes each one to its own output vector line, but only while software has opened the gate for it. There are 48 sources. Sources 0 to 31 come from PCI slots, and each PCI mapping register gates a group of four consecutive sources. Sources 32 to 47 come from on-board I/O devices, and each of these has a mapping register of its own. Every mapping register is 32 bits wide. Bit 31 is the enable bit and is the only bit that can be written. Bits 30:0 hold a fixed vector number. Separate write-only clear locations let the interrupt handler pull a request line low.

Software reaches the registers through a 32-bit read/write port that takes 16-bit byte offsets. Each register takes up an 8-byte slot, and only the upper word of the slot (address bit 2 set) is decoded. Each source has a three-state machine that turns its input level, its enable bit and its clear strobe into a registered output. A separate combinational helper turns a PCI device/function number and an interrupt pin into a source index, for a device on the primary bus or for one behind a secondary bridge.

Per-source state machine. There are three states:
- SRC_QUIET: output low.
- SRC_ASSERT: output high.
- SRC_SQUASH: output low after a clear.

There are six transitions:
- QUIET to ASSERT (raise): enabled, input high and no clear.
- QUIET to SQUASH (pre-clear): enabled, input high and clear.
- ASSERT to QUIET (drop): input low or enable off.
- ASSERT to SQUASH (clear): clear while enabled and high.
- SQUASH to QUIET (rearm): input low or enable off.
- Any other state to QUIET (recover): an encoding that is not legal.

Top module: `icm_irq_concentrator`

## Requirements
- R1: While `rst_n` is low and at the first sampling after its release, every `vec_out` bit is 0, `rsp_valid` is 0 and every enable bit is 0.
- R2: A read request with `req_write`=0 is answered one clock later with `rsp_valid`=1 and `rsp_rdata`. The PCI map register i sits at offset 0x0C04+8i (i<8) and reads {en, 0x7C0 | (i<<2)}. The I/O map register k sits at offset 0x1004+8k (k<32) and reads {en, 0x7E0 + k}. In both, en is bit 31.
- R3: A write to a map register sets its bit 31 to `req_wdata[31]`. Bits 30:0 of the register never change.
- R4: A read with `req_addr[2]`=0 returns 0. A write with `req_addr[2]`=0 changes no enable bit and clears no source.
- R5: `vec_out[s]` is 1 exactly when, at the previous clock edge, `src_level[s]` was 1, the gating enable was 1 and the source was not squashed. PCI source s (s<32) is gated by PCI map register s/4. Source 32+k is gated by I/O map register k. The output changes one clock after its input.
- R6: Writing with bit 2 set to offset 0x1404+8j (j<8) squashes source j. Writing to 0x1804+8k (k<=12) squashes source 32+k. The output goes low after that clock edge and stays low until the input has been sampled low. After that, it follows the input again.
- R7: A one-cycle `dev_reset` pulse clears every enable bit. The fixed bits 30:0 of the registers are left unchanged.
- R8: Reads of unmapped offsets and of the clear regions return 0. Writes to unmapped offsets have no effect. This includes 0x0C44, 0x1104, 0x1444 and 0x186C.
- R9: When `xl_secondary`=0, `xl_src` = `xl_pin` + 16·`xl_devfn[0]`.
- R10: When `xl_secondary`=1, `xl_src` = 4·`xl_devfn[4:3]` + `xl_pin`.
- R11: Clearing an enable bit drives every source it gates to 0 one clock after the register changes. This holds even while the input stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-up reset, active low, synchronous |
| dev_reset | input | 1 | Device reset pulse; clears enable bits only |
| req_valid | input | 1 | Register request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one clock after a read request |
| rsp_rdata | output | 32 | Read data |
| src_level | input | 48 | Interrupt source levels (PCI 0–31, I/O 32–47) |
| vec_out | output | 48 | Gated output vector lines |
| xl_devfn | input | 8 | Device/function number to translate |
| xl_pin | input | 2 | Interrupt pin, 0 = first pin |
| xl_secondary | input | 1 | 1 = device behind a secondary bridge |
| xl_src | output | 6 | Resulting source index |

## Verification
If an enable flop is lost or its index is decoded wrongly, the read-back of the register shows it in bit 31 one clock after the request. The output lines of the wrong group then show it at the next clock edge. A state machine stuck in SRC_SQUASH or SRC_ASSERT shows up on `vec_out` at the first sample after the input falls or rises. For that reason the gating sweep and the clear test change one level at a time and look at the lines every cycle. The translation is combinational, so an error in it can be seen on `xl_src` in the same cycle as the input.

// File: rtl/icm_pkg.sv
package icm_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;

    // Register region bases (byte offsets); each register owns an 8-byte slot.
    localparam logic [ADDR_W-1:0] PCI_MAP_BASE = 16'h0C00;
    localparam logic [ADDR_W-1:0] IO_MAP_BASE  = 16'h1000;
    localparam logic [ADDR_W-1:0] PCI_CLR_BASE = 16'h1400;
    localparam logic [ADDR_W-1:0] IO_CLR_BASE  = 16'h1800;

    typedef enum logic [1:0] {
        SRC_QUIET  = 2'd0,
        SRC_ASSERT = 2'd1,
        SRC_SQUASH = 2'd2
    } src_state_e;

    typedef enum logic [2:0] {
        RG_NONE    = 3'd0,
        RG_PCI_MAP = 3'd1,
        RG_IO_MAP  = 3'd2,
        RG_PCI_CLR = 3'd3,
        RG_IO_CLR  = 3'd4
    } region_e;

    // Fixed (read-only) vector fields of the mapping registers.
    function automatic logic [DATA_W-2:0] pci_fixed(input int unsigned idx);
        logic [DATA_W-1:0] v;
        v = (32'h1F << 6) | (32'(idx) << 2);
        return v[DATA_W-2:0];
    endfunction

    function automatic logic [DATA_W-2:0] io_fixed(input int unsigned idx);
        logic [DATA_W-1:0] v;
        v = ((32'h1F << 6) | 32'h20) + 32'(idx);
        return v[DATA_W-2:0];
    endfunction

endpackage

// File: rtl/icm_src_fsm.sv
module icm_src_fsm
    import icm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic enable,
    input  logic clear,
    output logic irq_out
);

    src_state_e st_q;
    src_state_e st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= SRC_QUIET;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SRC_QUIET: begin
                if (enable && level) begin
                    st_d = clear ? SRC_SQUASH : SRC_ASSERT;
                end
            end
            SRC_ASSERT: begin
                if (!enable || !level) begin
                    st_d = SRC_QUIET;
                end else if (clear) begin
                    st_d = SRC_SQUASH;
                end
            end
            SRC_SQUASH: begin
                if (!enable || !level) begin
                    st_d = SRC_QUIET;
                end
            end
            default: st_d = SRC_QUIET;
        endcase
    end

    always_comb begin
        irq_out = (st_q == SRC_ASSERT);
    end

endmodule

// File: rtl/icm_map_regs.sv
module icm_map_regs
    import icm_pkg::*;
#(
    parameter int N_PCI_MAP     = 8,
    parameter int N_IO_MAP      = 32,
    parameter int N_PCI_SRC     = 32,
    parameter int N_SRC         = 48,
    parameter int PCI_CLR_SLOTS = 8,
    parameter int IO_CLR_SLOTS  = 13
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 dev_reset,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic                 rsp_valid,
    output logic [DATA_W-1:0]    rsp_rdata,
    output logic [N_PCI_MAP-1:0] pci_en,
    output logic [N_IO_MAP-1:0]  io_en,
    output logic [N_SRC-1:0]     clr_vec
);

    localparam int SLOT_W = ADDR_W - 3;
    localparam logic [ADDR_W-1:0] PCI_MAP_SPAN = ADDR_W'(N_PCI_MAP * 8);
    localparam logic [ADDR_W-1:0] IO_MAP_SPAN  = ADDR_W'(N_IO_MAP * 8);
    localparam logic [ADDR_W-1:0] PCI_CLR_SPAN = ADDR_W'(PCI_CLR_SLOTS * 8);
    localparam logic [ADDR_W-1:0] IO_CLR_SPAN  = ADDR_W'(IO_CLR_SLOTS * 8);

    logic [ADDR_W-1:0] rel_pm, rel_im, rel_pc, rel_ic;
    logic [SLOT_W-1:0] slot_pm, slot_im, slot_pc, slot_ic;
    region_e           region;
    logic              wr_go, rd_go;
    logic [DATA_W-1:0] rd_word;
    logic              lint_unused;

    // Wrapped subtraction: an offset below the base wraps high and misses.
    assign rel_pm  = req_addr - PCI_MAP_BASE;
    assign rel_im  = req_addr - IO_MAP_BASE;
    assign rel_pc  = req_addr - PCI_CLR_BASE;
    assign rel_ic  = req_addr - IO_CLR_BASE;
    assign slot_pm = rel_pm[ADDR_W-1:3];
    assign slot_im = rel_im[ADDR_W-1:3];
    assign slot_pc = rel_pc[ADDR_W-1:3];
    assign slot_ic = rel_ic[ADDR_W-1:3];

    assign lint_unused = ^{req_wdata[DATA_W-2:0], req_addr[1:0],
                           rel_pm[2:0], rel_im[2:0], rel_pc[2:0], rel_ic[2:0]};

    always_comb begin
        if (rel_pm < PCI_MAP_SPAN) begin
            region = RG_PCI_MAP;
        end else if (rel_im < IO_MAP_SPAN) begin
            region = RG_IO_MAP;
        end else if (rel_pc < PCI_CLR_SPAN) begin
            region = RG_PCI_CLR;
        end else if (rel_ic < IO_CLR_SPAN) begin
            region = RG_IO_CLR;
        end else begin
            region = RG_NONE;
        end
    end

    assign wr_go = req_valid && req_write && req_addr[2];
    assign rd_go = req_valid && !req_write;

    // Enable bits: the only writable state of the mapping registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pci_en <= '0;
            io_en  <= '0;
        end else if (dev_reset) begin
            pci_en <= '0;
            io_en  <= '0;
        end else if (wr_go) begin
            for (int j = 0; j < N_PCI_MAP; j++) begin
                if (region == RG_PCI_MAP && slot_pm == SLOT_W'(j)) begin
                    pci_en[j] <= req_wdata[DATA_W-1];
                end
            end
            for (int k = 0; k < N_IO_MAP; k++) begin
                if (region == RG_IO_MAP && slot_im == SLOT_W'(k)) begin
                    io_en[k] <= req_wdata[DATA_W-1];
                end
            end
        end
    end

    // Clear strobes, one per source, valid in the request cycle.
    always_comb begin
        clr_vec = '0;
        if (wr_go && region == RG_PCI_CLR) begin
            for (int j = 0; j < PCI_CLR_SLOTS; j++) begin
                if (slot_pc == SLOT_W'(j)) begin
                    clr_vec[j] = 1'b1;
                end
            end
        end
        if (wr_go && region == RG_IO_CLR) begin
            for (int k = 0; k < IO_CLR_SLOTS; k++) begin
                if (slot_ic == SLOT_W'(k)) begin
                    clr_vec[N_PCI_SRC + k] = 1'b1;
                end
            end
        end
    end

    always_comb begin
        rd_word = '0;
        if (req_addr[2]) begin
            unique case (region)
                RG_PCI_MAP: begin
                    for (int j = 0; j < N_PCI_MAP; j++) begin
                        if (slot_pm == SLOT_W'(j)) begin
                            rd_word = {pci_en[j], pci_fixed(j)};
                        end
                    end
                end
                RG_IO_MAP: begin
                    for (int k = 0; k < N_IO_MAP; k++) begin
                        if (slot_im == SLOT_W'(k)) begin
                            rd_word = {io_en[k], io_fixed(k)};
                        end
                    end
                end
                default: rd_word = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd_go;
            rsp_rdata <= rd_go ? rd_word : '0;
        end
    end

endmodule

// File: rtl/icm_src_xlate.sv
module icm_src_xlate #(
    parameter int DEVFN_W = 8,
    parameter int PIN_W   = 2,
    parameter int SRC_W   = 6
) (
    input  logic [DEVFN_W-1:0] xl_devfn,
    input  logic [PIN_W-1:0]   xl_pin,
    input  logic               xl_secondary,
    output logic [SRC_W-1:0]   xl_src
);

    logic lint_unused;
    assign lint_unused = ^{xl_devfn[DEVFN_W-1:5], xl_devfn[2:1]};

    always_comb begin
        if (xl_secondary) begin
            // slot field (devfn bits 4:3) selects a group of four pins
            xl_src = SRC_W'({xl_devfn[4:3], xl_pin});
        end else begin
            // function bit 0 moves the pin into the upper half of the PCI range
            xl_src = SRC_W'({xl_devfn[0], 2'b00, xl_pin});
        end
    end

endmodule

// File: rtl/icm_irq_concentrator.sv
module icm_irq_concentrator
    import icm_pkg::*;
#(
    parameter int N_PCI_SRC     = 32,
    parameter int PCI_PER_MAP   = 4,
    parameter int N_IO_SRC      = 16,
    parameter int N_IO_MAP      = 32,
    parameter int PCI_CLR_SLOTS = 8,
    parameter int IO_CLR_SLOTS  = 13
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          dev_reset,
    input  logic                          req_valid,
    input  logic                          req_write,
    input  logic [15:0]                   req_addr,
    input  logic [31:0]                   req_wdata,
    output logic                          rsp_valid,
    output logic [31:0]                   rsp_rdata,
    input  logic [N_PCI_SRC+N_IO_SRC-1:0] src_level,
    output logic [N_PCI_SRC+N_IO_SRC-1:0] vec_out,
    input  logic [7:0]                    xl_devfn,
    input  logic [1:0]                    xl_pin,
    input  logic                          xl_secondary,
    output logic [5:0]                    xl_src
);

    localparam int N_SRC     = N_PCI_SRC + N_IO_SRC;
    localparam int N_PCI_MAP = N_PCI_SRC / PCI_PER_MAP;

    logic [N_PCI_MAP-1:0] pci_en;
    logic [N_IO_MAP-1:0]  io_en;
    logic [N_SRC-1:0]     src_en;
    logic [N_SRC-1:0]     clr_vec;

    icm_map_regs #(
        .N_PCI_MAP    (N_PCI_MAP),
        .N_IO_MAP     (N_IO_MAP),
        .N_PCI_SRC    (N_PCI_SRC),
        .N_SRC        (N_SRC),
        .PCI_CLR_SLOTS(PCI_CLR_SLOTS),
        .IO_CLR_SLOTS (IO_CLR_SLOTS)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .dev_reset(dev_reset),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata),
        .pci_en   (pci_en),
        .io_en    (io_en),
        .clr_vec  (clr_vec)
    );

    generate
        for (genvar s = 0; s < N_PCI_SRC; s++) begin : g_pci_gate
            assign src_en[s] = pci_en[s / PCI_PER_MAP];
        end
        for (genvar k = 0; k < N_IO_SRC; k++) begin : g_io_gate
            assign src_en[N_PCI_SRC + k] = io_en[k];
        end
        for (genvar s = 0; s < N_SRC; s++) begin : g_src
            icm_src_fsm u_fsm (
                .clk    (clk),
                .rst_n  (rst_n),
                .level  (src_level[s]),
                .enable (src_en[s]),
                .clear  (clr_vec[s]),
                .irq_out(vec_out[s])
            );
        end
    endgenerate

    icm_src_xlate #(
        .DEVFN_W(8),
        .PIN_W  (2),
        .SRC_W  (6)
    ) u_xlate (
        .xl_devfn    (xl_devfn),
        .xl_pin      (xl_pin),
        .xl_secondary(xl_secondary),
        .xl_src      (xl_src)
    );

endmodule

// File: rtl/icm_irq_concentrator_chk.sv
module icm_irq_concentrator_chk #(
    parameter int N_SRC     = 48,
    parameter int N_PCI_MAP = 8,
    parameter int N_IO_MAP  = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 dev_reset,
    input logic                 req_valid,
    input logic                 req_write,
    input logic                 req_addr2,
    input logic                 rsp_valid,
    input logic [31:0]          rsp_rdata,
    input logic [N_SRC-1:0]     src_level,
    input logic [N_SRC-1:0]     vec_out,
    input logic [N_SRC-1:0]     src_en,
    input logic [N_SRC-1:0]     clr_vec,
    input logic [N_PCI_MAP-1:0] pci_en,
    input logic [N_IO_MAP-1:0]  io_en,
    input logic                 xl_secondary,
    input logic [5:0]           xl_src
);

    p_out_needs_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_out & ~$past(src_level)) == '0);

    // also covers R11: a cleared enable leaves no line high one clock later
    p_out_needs_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_out & ~$past(src_en)) == '0);

    p_clear_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_vec) |=> ((vec_out & $past(clr_vec)) == '0));

    p_devrst_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dev_reset |=> (pci_en == '0 && io_en == '0));

    p_rsp_after_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && !req_write));

    p_low_word_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !$past(req_addr2)) |-> (rsp_rdata == '0));

    p_secondary_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        xl_secondary |-> (xl_src < 6'd16));

endmodule

bind icm_irq_concentrator icm_irq_concentrator_chk #(
    .N_SRC    (N_SRC),
    .N_PCI_MAP(N_PCI_MAP),
    .N_IO_MAP (N_IO_MAP)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dev_reset   (dev_reset),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_addr2   (req_addr[2]),
    .rsp_valid   (rsp_valid),
    .rsp_rdata   (rsp_rdata),
    .src_level   (src_level),
    .vec_out     (vec_out),
    .src_en      (src_en),
    .clr_vec     (clr_vec),
    .pci_en      (pci_en),
    .io_en       (io_en),
    .xl_secondary(xl_secondary),
    .xl_src      (xl_src)
);

// File: tb/icm_irq_concentrator_tb_top.sv
`timescale 1ns/1ps
module icm_irq_concentrator_tb_top;

    localparam logic [47:0] ALL = {48{1'b1}};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dev_reset = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [47:0] src_level = '0;
    logic [47:0] vec_out;
    logic [7:0]  xl_devfn = '0;
    logic [1:0]  xl_pin = '0;
    logic        xl_secondary = 1'b0;
    logic [5:0]  xl_src;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    icm_irq_concentrator dut_i (
        .clk(clk), .rst_n(rst_n), .dev_reset(dev_reset),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .src_level(src_level), .vec_out(vec_out),
        .xl_devfn(xl_devfn), .xl_pin(xl_pin), .xl_secondary(xl_secondary),
        .xl_src(xl_src)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [15:0] addr, input logic [31:0] data);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = addr; req_wdata = data;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic reg_read(input logic [15:0] addr, output logic [31:0] data, input string req);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = addr;
        @(negedge clk);
        req_valid = 1'b0;
        check({req, " rsp_valid"}, 64'(rsp_valid), 64'd1);
        data = rsp_rdata;
    endtask

    function automatic logic [15:0] map_off(input int r);
        return (r < 8) ? 16'(16'h0C04 + 8 * r) : 16'(16'h1004 + 8 * (r - 8));
    endfunction

    function automatic logic [31:0] fixed_val(input int r);
        return (r < 8) ? 32'(32'h7C0 | (r << 2)) : 32'(32'h7E0 + (r - 8));
    endfunction

    function automatic logic [47:0] gated_mask(input int r);
        logic [47:0] m;
        m = '0;
        if (r < 8) begin
            for (int b = 0; b < 4; b++) m[4 * r + b] = 1'b1;
        end else if (r - 8 < 16) begin
            m[32 + r - 8] = 1'b1;
        end
        return m;
    endfunction

    task automatic set_all_enables(input logic en);
        for (int r = 0; r < 40; r++) reg_write(map_off(r), {en, 31'h0});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog all-reqs actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic [5:0]  exp_src;

        // ---- R1: reset state
        repeat (3) @(negedge clk);
        check("R1 vec_out in reset", 64'(vec_out), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 vec_out after reset", 64'(vec_out), 64'd0);
        check("R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);

        // ---- R1/R2: power-up values of every map register
        for (int r = 0; r < 40; r++) begin
            reg_read(map_off(r), rd, "R2");
            check("R2 power-up value", 64'(rd), 64'(fixed_val(r)));
        end

        // ---- R4: low word reads zero, low word writes ignored
        for (int r = 0; r < 40; r++) begin
            reg_read(map_off(r) - 16'd4, rd, "R4");
            check("R4 low-word read", 64'(rd), 64'd0);
        end
        reg_write(16'h0C00, 32'hFFFF_FFFF);
        reg_write(16'h1000, 32'hFFFF_FFFF);
        reg_read(16'h0C04, rd, "R4");
        check("R4 low-word write ignored pci", 64'(rd), 64'(fixed_val(0)));
        reg_read(16'h1004, rd, "R4");
        check("R4 low-word write ignored io", 64'(rd), 64'(fixed_val(8)));

        // ---- R3: only bit 31 is writable
        for (int r = 0; r < 40; r++) begin
            reg_write(map_off(r), 32'hFFFF_FFFF);
            reg_read(map_off(r), rd, "R3");
            check("R3 set enable", 64'(rd), 64'({1'b1, 31'h0} | fixed_val(r)));
            reg_write(map_off(r), 32'h7FFF_FFFF);
            reg_read(map_off(r), rd, "R3");
            check("R3 clear enable", 64'(rd), 64'(fixed_val(r)));
        end

        // ---- R5/R11: gating sweep, one register at a time
        src_level = ALL;
        for (int r = 0; r < 40; r++) begin
            reg_write(map_off(r), 32'h8000_0000);
            @(negedge clk);
            check("R5 gate all-high", 64'(vec_out), 64'(gated_mask(r)));
            src_level = 48'hAAAA_5555_A5A5;
            @(negedge clk);
            check("R5 gate pattern", 64'(vec_out), 64'(gated_mask(r) & 48'hAAAA_5555_A5A5));
            src_level = ALL;
            @(negedge clk);
            reg_write(map_off(r), 32'h0);
            @(negedge clk);
            check("R11 disable forces low", 64'(vec_out), 64'd0);
        end

        // ---- R5: one-clock latency
        src_level = '0;
        set_all_enables(1'b1);
        @(negedge clk);
        src_level[5] = 1'b1;
        #1;
        check("R5 not before edge", 64'(vec_out), 64'd0);
        @(negedge clk);
        check("R5 after one edge", 64'(vec_out), 64'd1 << 5);
        src_level[5] = 1'b0;
        @(negedge clk);
        check("R5 falls after one edge", 64'(vec_out), 64'd0);

        // ---- R6: clear registers
        src_level = ALL;
        @(negedge clk);
        check("R6 all asserted", 64'(vec_out), 64'(ALL));
        for (int c = 0; c < 21; c++) begin
            int s;
            logic [15:0] a;
            s = (c < 8) ? c : 32 + (c - 8);
            a = (c < 8) ? 16'(16'h1404 + 8 * c) : 16'(16'h1804 + 8 * (c - 8));
            reg_write(a, 32'h0);
            check("R6 squashed", 64'(vec_out), 64'(ALL & ~(48'd1 << s)));
            @(negedge clk);
            check("R6 stays squashed", 64'(vec_out), 64'(ALL & ~(48'd1 << s)));
            src_level[s] = 1'b0;
            @(negedge clk);
            src_level[s] = 1'b1;
            @(negedge clk);
            check("R6 rearmed", 64'(vec_out), 64'(ALL));
        end
        // clear with bit 2 low, and past the last I/O clear slot
        reg_write(16'h1400, 32'h0);
        check("R4 low-word clear ignored", 64'(vec_out), 64'(ALL));
        reg_write(16'h186C, 32'h0);
        check("R8 beyond io clear ignored", 64'(vec_out), 64'(ALL));
        reg_write(16'h1444, 32'h0);
        check("R8 beyond pci clear ignored", 64'(vec_out), 64'(ALL));
        reg_read(16'h1404, rd, "R8");
        check("R8 clear region reads zero", 64'(rd), 64'd0);
        reg_read(16'h1804, rd, "R8");
        check("R8 io clear region reads zero", 64'(rd), 64'd0);

        // ---- R8: unmapped offsets
        set_all_enables(1'b0);
        reg_write(16'h0C44, 32'hFFFF_FFFF);
        reg_write(16'h1104, 32'hFFFF_FFFF);
        reg_write(16'h2004, 32'hFFFF_FFFF);
        @(negedge clk);
        check("R8 unmapped write no effect", 64'(vec_out), 64'd0);
        reg_read(16'h0C44, rd, "R8");
        check("R8 unmapped read", 64'(rd), 64'd0);
        reg_read(16'h1104, rd, "R8");
        check("R8 unmapped read", 64'(rd), 64'd0);
        reg_read(16'h2004, rd, "R8");
        check("R8 unmapped read", 64'(rd), 64'd0);
        reg_read(16'h0C3C, rd, "R8");
        check("R8 last pci reg unchanged", 64'(rd), 64'(fixed_val(7)));

        // ---- R7: device reset
        set_all_enables(1'b1);
        @(negedge clk);
        check("R7 pre-reset asserted", 64'(vec_out), 64'(ALL));
        dev_reset = 1'b1;
        @(negedge clk);
        dev_reset = 1'b0;
        @(negedge clk);
        check("R7 outputs low", 64'(vec_out), 64'd0);
        for (int r = 0; r < 40; r++) begin
            reg_read(map_off(r), rd, "R7");
            check("R7 enable cleared, field kept", 64'(rd), 64'(fixed_val(r)));
        end
        src_level = '0;

        // ---- R9/R10: translation sweep
        for (int sec = 0; sec < 2; sec++) begin
            for (int d = 0; d < 256; d++) begin
                for (int p = 0; p < 4; p++) begin
                    @(negedge clk);
                    xl_secondary = sec[0];
                    xl_devfn = 8'(d);
                    xl_pin = 2'(p);
                    #1;
                    if (sec == 1) begin
                        exp_src = 6'(((d & 8'h18) >> 1) + p);
                        check("R10 secondary xlate", 64'(xl_src), 64'(exp_src));
                    end else begin
                        exp_src = 6'(p + ((d & 1) ? 16 : 0));
                        check("R9 primary xlate", 64'(xl_src), 64'(exp_src));
                    end
                end
            end
        end

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule